// File: doc/BRIEF.md
# Codec Control Register Bank

This block is the software-visible register file of an audio codec controller. A processor reaches it over a simple 32-bit word bus with a byte address. It holds three groups of registers. The first group handles access to the external codec's registers: a command word, a codec register address, outgoing data and incoming data. The second and third groups hold the control word, buffer address and remaining byte count for the playback channel and for the capture channel.

The command word carries a request flag in bit 0 and a direction flag in bit 1. A bus write that sets the request flag produces a single-cycle pulse on one of two interrupt lines, and the direction flag picks which line. The request flag itself is never kept. Bit 0 of each channel control word drives that channel's enable output. The two DMA engines can overwrite a channel's address and remaining count, and a bus write to the same register in the same cycle takes precedence.

Top module: `codec_reg_bank`

## Requirements
- R1: After reset every register reads zero and the outputs play_en, cap_en, irq_cr_request and irq_cr_reply are low.
- R2: The register index is the byte address shifted right by two, so address bits [1:0] are ignored. The registers are: 0x00 command, 0x04 codec address, 0x08 data out, 0x0C data in, 0x10 playback control, 0x14 playback address, 0x18 playback remaining, 0x20 capture control, 0x24 capture address, 0x28 capture remaining. Each one stores a written 32-bit word and returns it on bus_rdata, which is combinational from bus_addr.
- R3: The command register stores the written word with bit 0 cleared, so bit 0 always reads back as 0.
- R4: A write to the command register with bit 0 = 1 and bit 1 = 1 raises irq_cr_request for exactly one cycle. The pulse appears in the cycle after the write edge, and irq_cr_reply stays low.
- R5: A write to the command register with bit 0 = 1 and bit 1 = 0 raises irq_cr_reply for exactly one cycle. The pulse appears in the cycle after the write edge, and irq_cr_request stays low.
- R6: No interrupt pulse occurs without such a write, including command writes that have bit 0 = 0.
- R7: play_en equals bit 0 of the playback control register, and cap_en equals bit 0 of the capture control register.
- R8: The reserved word at 0x1C and every address from 0x2C upward read zero. Writes to them change no register and raise no interrupt.
- R9: A cycle with play_upd_we (or cap_upd_we) high loads that channel's address and remaining registers from the update inputs, unless the bus writes those registers in the same cycle.
- R10: When the bus and a DMA update target the same channel register in the same cycle, the bus value is stored.
- R11: play_addr, play_remaining, cap_addr and cap_remaining always present the stored channel register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_cr_request | output | 1 | Codec request interrupt pulse |
| irq_cr_reply | output | 1 | Codec reply interrupt pulse |
| play_en | output | 1 | Playback channel enable |
| cap_en | output | 1 | Capture channel enable |
| play_upd_we | input | 1 | Playback DMA update strobe |
| play_upd_addr | input | 32 | Playback DMA new address |
| play_upd_rem | input | 32 | Playback DMA new remaining count |
| cap_upd_we | input | 1 | Capture DMA update strobe |
| cap_upd_addr | input | 32 | Capture DMA new address |
| cap_upd_rem | input | 32 | Capture DMA new remaining count |
| play_addr | output | 32 | Stored playback address |
| play_remaining | output | 32 | Stored playback remaining count |
| cap_addr | output | 32 | Stored capture address |
| cap_remaining | output | 32 | Stored capture remaining count |

## Verification
A corrupted register shows up on the first read of its offset and, for the channel registers, at once on the DMA-facing outputs. A wrong enable bit shows on play_en or cap_en in the cycle after the write. A fault in address decode shows up as a wrong word or a nonzero reserved read, or as a bus write that lands in a different register, and the bench catches it when it next reads the mirror of every register. A fault in the pulse logic shows up on the interrupt lines one cycle after the write: a missing or stretched pulse, or a pulse on the wrong line.

// File: rtl/crb_pkg.sv
// Shared constants for the codec control register bank.
// Assumes 32-bit words and word indices decoded from byte address >> 2.
package crb_pkg;
    localparam int NUM_WORDS    = 11;
    localparam int IDX_CMD      = 0;
    localparam int IDX_CADDR    = 1;
    localparam int IDX_DOUT     = 2;
    localparam int IDX_DIN      = 3;
    localparam int IDX_RESERVED = 7;
    localparam int CH_STRIDE    = 4;
    localparam int CH_BASE      = 4;   // playback control; capture at +CH_STRIDE
    localparam int OFF_CTRL     = 0;
    localparam int OFF_ADDR     = 1;
    localparam int OFF_REM      = 2;
    localparam int REQ_BIT      = 0;
    localparam int DIR_BIT      = 1;
    localparam int EN_BIT       = 0;
endpackage

// File: rtl/crb_decode.sv
// Address decoder: turns a byte address into a one-hot word select.
// Assumes: address bits [1:0] are ignored; the reserved word and indices
// past the map select nothing.
module crb_decode
    import crb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_WORDS-1:0] sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_low;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_low = ^addr[1:0];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
        if (i == IDX_RESERVED) begin : g_res
            // Reserved word never selects storage.
            assign sel[i] = 1'b0;
        end else begin : g_live
            // Word i is selected when the index matches.
            assign sel[i] = (int'(idx) == i);
        end
    end
endmodule

// File: rtl/crb_cmd.sv
// Command register with the self-clearing request flag and the two
// direction-selected interrupt pulses (one cycle, in the cycle after the write).
// Assumes: wr_en is already qualified by address decode.
module crb_cmd
    import crb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic              irq_req,
    output logic              irq_rep
);
    logic [DATA_W-1:0] clr_mask;

    assign clr_mask = ~(DATA_W'(1) << REQ_BIT);

    // Store the command word with the request flag removed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en) begin
            cmd_q <= wdata & clr_mask;
        end
    end

    // Pulse the interrupt line chosen by the direction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_rep <= 1'b0;
        end else begin
            irq_req <= wr_en &  wdata[REQ_BIT] &  wdata[DIR_BIT];
            irq_rep <= wr_en &  wdata[REQ_BIT] & ~wdata[DIR_BIT];
        end
    end
endmodule

// File: rtl/crb_word.sv
// Plain read/write word register, cleared by reset.
// Assumes: wr_en is already qualified by address decode.
module crb_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Load on a bus write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/crb_channel.sv
// One DMA channel's control, address and remaining registers.
// The DMA update loads address and remaining; a bus write to the same
// register in the same cycle takes precedence. Enable is control bit EN_BIT.
module crb_channel
    import crb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic              wr_rem,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd_we,
    input  logic [DATA_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_rem,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] rem_q,
    output logic              en
);
    // Control word: bus only.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    // Buffer address: bus first, then DMA update.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (wr_addr) addr_q <= wdata;
        else if (upd_we)  addr_q <= upd_addr;
    end

    // Remaining count: bus first, then DMA update.
    always_ff @(posedge clk) begin
        if (!rst_n)      rem_q <= '0;
        else if (wr_rem) rem_q <= wdata;
        else if (upd_we) rem_q <= upd_rem;
    end

    assign en = ctrl_q[EN_BIT];
endmodule

// File: rtl/codec_reg_bank.sv
// Codec control register bank top: decodes the word bus, holds the codec
// access and two DMA channel register groups, and muxes read data.
// Assumes single-cycle writes and combinational reads from bus_addr.
module codec_reg_bank
    import crb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_cr_request,
    output logic              irq_cr_reply,
    output logic              play_en,
    output logic              cap_en,
    input  logic              play_upd_we,
    input  logic [DATA_W-1:0] play_upd_addr,
    input  logic [DATA_W-1:0] play_upd_rem,
    input  logic              cap_upd_we,
    input  logic [DATA_W-1:0] cap_upd_addr,
    input  logic [DATA_W-1:0] cap_upd_rem,
    output logic [DATA_W-1:0] play_addr,
    output logic [DATA_W-1:0] play_remaining,
    output logic [DATA_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_remaining
);
    localparam int NUM_CH = 2;
    localparam int NUM_PLAIN = 3;   // codec address, data out, data in

    logic [NUM_WORDS-1:0] sel;
    logic [NUM_WORDS-1:0] wr;
    logic [DATA_W-1:0]    words [NUM_WORDS];

    logic [NUM_CH-1:0]    ch_upd_we;
    logic [DATA_W-1:0]    ch_upd_addr [NUM_CH];
    logic [DATA_W-1:0]    ch_upd_rem  [NUM_CH];
    logic [NUM_CH-1:0]    ch_en;
    logic [DATA_W-1:0]    ch_addr [NUM_CH];
    logic [DATA_W-1:0]    ch_rem  [NUM_CH];

    crb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr = sel & {NUM_WORDS{bus_we}};

    crb_cmd #(.DATA_W(DATA_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr[IDX_CMD]),
        .wdata   (bus_wdata),
        .cmd_q   (words[IDX_CMD]),
        .irq_req (irq_cr_request),
        .irq_rep (irq_cr_reply)
    );

    for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
        crb_word #(.DATA_W(DATA_W)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr[IDX_CADDR + p]),
            .wdata (bus_wdata),
            .q     (words[IDX_CADDR + p])
        );
    end

    assign words[IDX_RESERVED] = '0;

    assign ch_upd_we[0]   = play_upd_we;
    assign ch_upd_addr[0] = play_upd_addr;
    assign ch_upd_rem[0]  = play_upd_rem;
    assign ch_upd_we[1]   = cap_upd_we;
    assign ch_upd_addr[1] = cap_upd_addr;
    assign ch_upd_rem[1]  = cap_upd_rem;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = CH_BASE + c * CH_STRIDE;
        crb_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr[BASE + OFF_CTRL]),
            .wr_addr  (wr[BASE + OFF_ADDR]),
            .wr_rem   (wr[BASE + OFF_REM]),
            .wdata    (bus_wdata),
            .upd_we   (ch_upd_we[c]),
            .upd_addr (ch_upd_addr[c]),
            .upd_rem  (ch_upd_rem[c]),
            .ctrl_q   (words[BASE + OFF_CTRL]),
            .addr_q   (words[BASE + OFF_ADDR]),
            .rem_q    (words[BASE + OFF_REM]),
            .en       (ch_en[c])
        );
        assign ch_addr[c] = words[BASE + OFF_ADDR];
        assign ch_rem[c]  = words[BASE + OFF_REM];
    end

    // Read mux: OR of the selected word; nothing selected reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (sel[i]) bus_rdata = bus_rdata | words[i];
        end
    end

    assign play_en        = ch_en[0];
    assign cap_en         = ch_en[1];
    assign play_addr      = ch_addr[0];
    assign play_remaining = ch_rem[0];
    assign cap_addr       = ch_addr[1];
    assign cap_remaining  = ch_rem[1];
endmodule

// File: rtl/crb_checker.sv
// Assertion checker for codec_reg_bank, attached by bind below.
module crb_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_cr_request,
    input logic              irq_cr_reply,
    input logic              play_en,
    input logic              cap_en,
    input logic              play_upd_we,
    input logic [DATA_W-1:0] play_addr
);
    logic [ADDR_W-3:0] idx;
    logic              cmd_wr;
    assign idx    = bus_addr[ADDR_W-1:2];
    assign cmd_wr = bus_we && (idx == '0);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!play_en && !cap_en && !irq_cr_request && !irq_cr_reply));

    a_r3_req_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0) |-> !bus_rdata[0]);

    a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[1:0] == 2'b11) |=> (irq_cr_request && !irq_cr_reply));

    a_r5_rep_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[1:0] == 2'b01) |=> (irq_cr_reply && !irq_cr_request));

    a_r6_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cr_request |-> $past(cmd_wr && bus_wdata[1:0] == 2'b11));

    a_r6_rep_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cr_reply |-> $past(cmd_wr && bus_wdata[1:0] == 2'b01));

    a_r7_play_en_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) == 4) |-> (bus_rdata[0] == play_en));

    a_r7_cap_en_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) == 8) |-> (bus_rdata[0] == cap_en));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) == 7 || int'(idx) >= 11) |-> (bus_rdata == '0));

    a_r10_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(idx) == 5 && play_upd_we) |=> (play_addr == $past(bus_wdata)));
endmodule

bind codec_reg_bank crb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .irq_cr_request (irq_cr_request),
    .irq_cr_reply   (irq_cr_reply),
    .play_en        (play_en),
    .cap_en         (cap_en),
    .play_upd_we    (play_upd_we),
    .play_addr      (play_addr)
);

// File: tb/sim_codec_reg_bank.sv
`timescale 1ns/1ps
module sim_codec_reg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_cr_request, irq_cr_reply, play_en, cap_en;
    logic        play_upd_we = 1'b0, cap_upd_we = 1'b0;
    logic [31:0] play_upd_addr = '0, play_upd_rem = '0, cap_upd_addr = '0, cap_upd_rem = '0;
    logic [31:0] play_addr, play_remaining, cap_addr, cap_remaining;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m [11];   // bench mirror of the register map

    always #2.5 clk = ~clk;

    codec_reg_bank u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected read value at a byte address (R2, R8).
    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int i = int'(a[7:2]);
        if (i == 7 || i >= 11) return 32'h0;
        return m[i];
    endfunction

    // One bus/DMA cycle with mirror update and port checks.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic pu, input logic [31:0] pa, input logic [31:0] pr,
                        input logic cu, input logic [31:0] ca, input logic [31:0] cr);
        int i = int'(a[7:2]);
        logic er, ep;
        @(negedge clk);
        chk("R6 idle request low", {31'b0, irq_cr_request}, 32'h0);
        chk("R6 idle reply low",   {31'b0, irq_cr_reply},   32'h0);
        bus_we = we; bus_addr = a; bus_wdata = d;
        play_upd_we = pu; play_upd_addr = pa; play_upd_rem = pr;
        cap_upd_we = cu;  cap_upd_addr = ca;  cap_upd_rem = cr;
        if (pu) begin m[5] = pa; m[6] = pr; end
        if (cu) begin m[9] = ca; m[10] = cr; end
        er = we && i == 0 && d[1:0] == 2'b11;
        ep = we && i == 0 && d[1:0] == 2'b01;
        if (we && i < 11 && i != 7) m[i] = (i == 0) ? (d & ~32'h1) : d;
        @(negedge clk);
        bus_we = 1'b0; play_upd_we = 1'b0; cap_upd_we = 1'b0;
        chk("R4 request pulse", {31'b0, irq_cr_request}, {31'b0, er});
        chk("R5 reply pulse",   {31'b0, irq_cr_reply},   {31'b0, ep});
        chk("R7 play_en", {31'b0, play_en}, {31'b0, m[4][0]});
        chk("R7 cap_en",  {31'b0, cap_en},  {31'b0, m[8][0]});
        chk("R11 play_addr", play_addr, m[5]);
        chk("R11 play_remaining", play_remaining, m[6]);
        chk("R11 cap_addr", cap_addr, m[9]);
        chk("R11 cap_remaining", cap_remaining, m[10]);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 12; k++) rd(tag, 8'(k * 4));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 0, 0, 1'b0, 0, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        for (int k = 0; k < 11; k++) m[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_all("R1 reset value");
        chk("R1 play_en", {31'b0, play_en}, 32'h0);
        chk("R1 cap_en",  {31'b0, cap_en},  32'h0);
        chk("R1 irq",     {30'b0, irq_cr_request, irq_cr_reply}, 32'h0);
        // R2: each register, low address bits ignored
        for (int k = 1; k < 11; k++) if (k != 7) wr(8'(k * 4 + (k % 4)), 32'hA500_0000 + 32'(k));
        rd_all("R2 readback");
        rd("R2 low bits ignored", 8'h17);
        // R3/R4/R5/R6: command register
        wr(8'h00, 32'h0000_1233); rd("R3 request bit cleared", 8'h00);
        wr(8'h00, 32'h0000_0001); rd("R3 reply write", 8'h00);
        wr(8'h00, 32'hFFFF_FFFE); rd("R6 no request", 8'h00);
        wr(8'h00, 32'h0000_0003); wr(8'h00, 32'h0000_0003);
        // R7: enables
        wr(8'h10, 32'h1); wr(8'h20, 32'h1); wr(8'h10, 32'h0);
        // R8: reserved and out of map
        wr(8'h1C, 32'hFFFF_FFFF); wr(8'h2C, 32'h0000_0003); wr(8'hFC, 32'h0000_0003);
        rd_all("R8 writes ignored");
        rd("R8 reserved", 8'h1C); rd("R8 out of map", 8'h2C); rd("R8 top", 8'hFC);
        // R9: DMA updates
        step(1'b0, 8'h00, 0, 1'b1, 32'h1000, 32'h40, 1'b1, 32'h2000, 32'h80);
        rd_all("R9 dma load");
        // R10: bus wins
        step(1'b1, 8'h14, 32'hBEEF, 1'b1, 32'h3000, 32'h10, 1'b0, 0, 0);
        rd("R10 bus wins addr", 8'h14); rd("R9 rem from dma", 8'h18);
        step(1'b1, 8'h28, 32'hCAFE, 1'b0, 0, 0, 1'b1, 32'h4000, 32'h20);
        rd("R10 bus wins rem", 8'h28); rd("R9 addr from dma", 8'h24);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a = 8'($urandom_range(0, 15) * 4 + $urandom_range(0, 3));
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 3) == 0) d[1:0] = 2'($urandom_range(0, 3));
            step(1'($urandom_range(0, 1)), a, d,
                 1'($urandom_range(0, 3) == 0), $urandom, $urandom,
                 1'($urandom_range(0, 3) == 0), $urandom, $urandom);
            rd("R2 random read", 8'($urandom_range(0, 63) * 4));
        end
        rd_all("R2 final");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule